// File: doc/BRIEF.md
# Slot-Vectored Interrupt Controller

This block gathers up to 32 level-sensitive request lines and drives the two interrupt inputs of a processor core: a fast interrupt and a normal interrupt. Software chooses which sources take part through a set-only enable register and a clear-only companion. A per-source type bit then steers each active, enabled request to one of the two core inputs.

Normal requests are ranked by a bank of numbered vector slots. Each slot binds a chosen source number to a handler address, and the slot index fixes the priority, with slot 0 the highest. On every cycle the controller finds the lowest-numbered enabled slot whose source is a pending normal request. It latches that slot's handler address into a vector register, or latches a programmable fallback address when no slot matches. Software reads the vector register on entry to its normal handler, so one load gives the jump target.

All registers are on a simple memory-mapped bus with one-cycle registered read data.

Top module: `vic_slots`

## Requirements
- R1: After synchronous reset the enable, type, slot-control and fallback-address registers read 0, both interrupt outputs are low, and the vector register reads 0.
- R2: A write to the enable register (offset 0x0C) sets every enable bit where the write data is 1, leaves bits written 0 unchanged, and a read of 0x0C returns the enables.
- R3: A write to the enable-clear register (offset 0x10) clears every enable bit where the write data is 1, leaves bits written 0 unchanged, and a read of 0x10 returns 0.
- R4: A type bit of 1 (register at offset 0x14, read/write) steers that source to `fiq_o`, and 0 steers it to `irq_o`. Each output is high one clock after any active, enabled source of its type is present.
- R5: Offset 0x00 reads the unmasked request levels, offset 0x04 reads active, enabled, normal-typed requests, and offset 0x08 reads active, enabled, fast-typed requests.
- R6: Sixteen slot-control registers sit at offset 0x40 + 4*n. Bit 5 is the slot enable, bits 4:0 are the source number, and a read returns bits 5:0 with all higher bits 0.
- R7: Sixteen slot handler-address registers sit at offset 0x80 + 4*n, each holding a full 32-bit value that reads back as written.
- R8: The vector register (offset 0x18) returns the handler address of the lowest-numbered enabled slot whose source is an active, enabled, normal-typed request. When no slot matches, it returns the fallback address register (offset 0x1C, read/write).
- R9: `irq_o` is raised for an active, enabled, normal-typed source even when no slot names that source.
- R10: A source typed fast never selects a vector slot, even when an enabled slot names it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_in | input | 32 | Level-sensitive interrupt request lines |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after the read strobe |
| fiq_o | output | 1 | Fast interrupt to the core |
| irq_o | output | 1 | Normal interrupt to the core |

## Verification
The hardest case to reach is a vector choice that depends on ranking. Several enabled slots must name pending normal sources while a higher-ranked slot names a source that is disabled, typed fast or idle, so that the winner is not the first slot. Directed cases build these patterns: duplicate sources, a fast-typed source under slot 0, and no slot matching. Random rounds then reprogram slots, enables and types with dense request vectors, and every round compares the vector register and both outputs against a bench-side ranking model.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int REG_AW = 8;
  localparam int DW     = 32;

  localparam logic [REG_AW-1:0] OFS_RAW  = 8'h00;
  localparam logic [REG_AW-1:0] OFS_IRQS = 8'h04;
  localparam logic [REG_AW-1:0] OFS_FIQS = 8'h08;
  localparam logic [REG_AW-1:0] OFS_EN   = 8'h0C;
  localparam logic [REG_AW-1:0] OFS_CLR  = 8'h10;
  localparam logic [REG_AW-1:0] OFS_TYPE = 8'h14;
  localparam logic [REG_AW-1:0] OFS_VECT = 8'h18;
  localparam logic [REG_AW-1:0] OFS_DEF  = 8'h1C;

  // upper two offset bits pick the slot regions
  localparam logic [1:0] REGION_CTL = 2'b01;
  localparam logic [1:0] REGION_ADR = 2'b10;
endpackage

// File: rtl/vic_src_regs.sv
module vic_src_regs #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we_set,
  input  logic            we_clr,
  input  logic            we_type,
  input  logic [NSRC-1:0] wbits,
  input  logic [NSRC-1:0] req,
  output logic [NSRC-1:0] en_q,
  output logic [NSRC-1:0] type_q,
  output logic [NSRC-1:0] irq_stat,
  output logic [NSRC-1:0] fiq_stat
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      type_q <= '0;
    end else begin
      if (we_set)      en_q <= en_q | wbits;
      else if (we_clr) en_q <= en_q & ~wbits;
      if (we_type)     type_q <= wbits;
    end
  end

  always_comb begin
    irq_stat = req & en_q & ~type_q;
    fiq_stat = req & en_q & type_q;
  end
endmodule

// File: rtl/vic_prio_pick.sv
module vic_prio_pick #(
  parameter int N = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  hit,
  output logic [IW-1:0] win,
  output logic          valid
);
  always_comb begin
    win   = '0;
    valid = 1'b0;
    // scan downward so the lowest index is the last one taken
    for (int i = N - 1; i >= 0; i--) begin
      if (hit[i]) begin
        win   = IW'(i);
        valid = 1'b1;
      end
    end
  end
endmodule

// File: rtl/vic_slot_bank.sv
module vic_slot_bank #(
  parameter int NSRC  = 32,
  parameter int NSLOT = 16,
  parameter int DW    = 32,
  localparam int SW   = $clog2(NSRC),
  localparam int IW   = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ctl_we,
  input  logic                     adr_we,
  input  logic [IW-1:0]            idx,
  input  logic [DW-1:0]            wdata,
  input  logic [NSRC-1:0]          irq_stat,
  input  logic [DW-1:0]            def_addr,
  output logic [NSLOT-1:0][SW:0]   ctl_q,
  output logic [DW-1:0]            adr_rd_q,
  output logic [DW-1:0]            vect_q
);
  logic [DW-1:0]    adr_mem [NSLOT];
  logic [NSLOT-1:0] hit;
  logic [IW-1:0]    win;
  logic             win_valid;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)
        ctl_q[s] <= '0;
      else if (ctl_we && idx == IW'(s))
        ctl_q[s] <= wdata[SW:0];
    end
    assign hit[s] = ctl_q[s][SW] & irq_stat[ctl_q[s][SW-1:0]];
  end

  vic_prio_pick #(.N(NSLOT)) pick_i (
    .hit   (hit),
    .win   (win),
    .valid (win_valid)
  );

  // handler address storage, no reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (adr_we) adr_mem[idx] <= wdata;
    adr_rd_q <= adr_mem[idx];
  end

  always_ff @(posedge clk) begin
    if (rst)            vect_q <= '0;
    else if (win_valid) vect_q <= adr_mem[win];
    else                vect_q <= def_addr;
  end
endmodule

// File: rtl/vic_slots.sv
module vic_slots
  import vic_pkg::*;
#(
  parameter int NSRC  = 32,
  parameter int NSLOT = 16,
  localparam int SW   = $clog2(NSRC),
  localparam int IW   = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   req_in,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              fiq_o,
  output logic              irq_o
);
  logic             wr_en, rd_en;
  logic [1:0]       region;
  logic [IW-1:0]    idx;
  logic             idx_ok;
  logic [NSRC-1:0]  en_q, type_q, irq_stat, fiq_stat;
  logic [NSLOT-1:0][SW:0] ctl_q;
  logic [DW-1:0]    adr_rd_q, vect_q, def_q, reg_rd_q;
  logic             mem_rd_q;
  logic             unused_bits;

  assign wr_en  = bus_sel & bus_wr;
  assign rd_en  = bus_sel & ~bus_wr;
  assign region = bus_addr[REG_AW-1:REG_AW-2];
  assign idx    = bus_addr[2 +: IW];
  assign idx_ok = (32'(idx) < NSLOT);
  assign unused_bits = ^bus_addr[1:0];

  vic_src_regs #(.NSRC(NSRC)) src_i (
    .clk      (clk),
    .rst      (rst),
    .we_set   (wr_en && bus_addr == OFS_EN),
    .we_clr   (wr_en && bus_addr == OFS_CLR),
    .we_type  (wr_en && bus_addr == OFS_TYPE),
    .wbits    (bus_wdata[NSRC-1:0]),
    .req      (req_in),
    .en_q     (en_q),
    .type_q   (type_q),
    .irq_stat (irq_stat),
    .fiq_stat (fiq_stat)
  );

  vic_slot_bank #(.NSRC(NSRC), .NSLOT(NSLOT), .DW(DW)) bank_i (
    .clk      (clk),
    .rst      (rst),
    .ctl_we   (wr_en && region == REGION_CTL && idx_ok),
    .adr_we   (wr_en && region == REGION_ADR && idx_ok),
    .idx      (idx),
    .wdata    (bus_wdata),
    .irq_stat (irq_stat),
    .def_addr (def_q),
    .ctl_q    (ctl_q),
    .adr_rd_q (adr_rd_q),
    .vect_q   (vect_q)
  );

  always_ff @(posedge clk) begin
    if (rst) def_q <= '0;
    else if (wr_en && bus_addr == OFS_DEF) def_q <= bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fiq_o <= 1'b0;
      irq_o <= 1'b0;
    end else begin
      fiq_o <= |fiq_stat;
      irq_o <= |irq_stat;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rd_q <= '0;
      mem_rd_q <= 1'b0;
    end else begin
      mem_rd_q <= rd_en && region == REGION_ADR && idx_ok;
      reg_rd_q <= '0;
      if (rd_en) begin
        if (region == REGION_CTL) begin
          if (idx_ok) reg_rd_q <= DW'(ctl_q[idx]);
        end else begin
          case (bus_addr)
            OFS_RAW:  reg_rd_q <= DW'(req_in);
            OFS_IRQS: reg_rd_q <= DW'(irq_stat);
            OFS_FIQS: reg_rd_q <= DW'(fiq_stat);
            OFS_EN:   reg_rd_q <= DW'(en_q);
            OFS_TYPE: reg_rd_q <= DW'(type_q);
            OFS_VECT: reg_rd_q <= vect_q;
            OFS_DEF:  reg_rd_q <= def_q;
            default:  reg_rd_q <= '0;
          endcase
        end
      end
    end
  end

  assign bus_rdata = mem_rd_q ? adr_rd_q : reg_rd_q;
endmodule

// File: rtl/vic_slots_chk.sv
module vic_slots_chk
  import vic_pkg::*;
#(
  parameter int NSRC = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [REG_AW-1:0] bus_addr,
  input logic [DW-1:0]     bus_wdata,
  input logic [NSRC-1:0]   en_q,
  input logic [NSRC-1:0]   irq_stat,
  input logic [NSRC-1:0]   fiq_stat,
  input logic              fiq_o,
  input logic              irq_o
);
  logic seen_q;
  always_ff @(posedge clk) begin
    if (rst) seen_q <= 1'b0;
    else     seen_q <= 1'b1;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (!fiq_o && !irq_o));

  // R2
  enable_set_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_wr && bus_addr == OFS_EN) |=>
      ((en_q & $past(bus_wdata[NSRC-1:0])) == $past(bus_wdata[NSRC-1:0])));

  // R3
  enable_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_wr && bus_addr == OFS_CLR) |=>
      ((en_q & $past(bus_wdata[NSRC-1:0])) == '0));

  // R4
  fiq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    seen_q |-> (fiq_o == $past(|fiq_stat)));

  // R9
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    seen_q |-> (irq_o == $past(|irq_stat)));

  // R5
  steer_disjoint_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_stat & fiq_stat) == '0);
endmodule

bind vic_slots vic_slots_chk #(.NSRC(NSRC)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .en_q      (en_q),
  .irq_stat  (irq_stat),
  .fiq_stat  (fiq_stat),
  .fiq_o     (fiq_o),
  .irq_o     (irq_o)
);

// File: tb/vic_slots_tb_top.sv
module vic_slots_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] req_in = '0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        fiq_o, irq_o;

  int errors = 0;
  int checks = 0;

  logic [31:0] m_en = '0, m_type = '0, m_def = '0;
  logic [5:0]  m_ctl [16];
  logic [31:0] m_adr [16];

  always #4 clk = ~clk;

  vic_slots dut_i (
    .clk(clk), .rst(rst), .req_in(req_in), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .fiq_o(fiq_o), .irq_o(irq_o)
  );

  function automatic logic [31:0] exp_vect();
    logic [31:0] pend = req_in & m_en & ~m_type;
    for (int s = 0; s < 16; s++)
      if (m_ctl[s][5] && pend[m_ctl[s][4:0]]) return m_adr[s];
    return m_def;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    if (a == 8'h0C) m_en = m_en | d;
    else if (a == 8'h10) m_en = m_en & ~d;
    else if (a == 8'h14) m_type = d;
    else if (a == 8'h1C) m_def = d;
    else if (a[7:6] == 2'b01) m_ctl[a[5:2]] = d[5:0];
    else if (a[7:6] == 2'b10) m_adr[a[5:2]] = d;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic full_check(string ctx);
    logic [31:0] v;
    check({"R4 fiq_o ", ctx}, 32'(fiq_o), 32'(|(req_in & m_en & m_type)));
    check({"R9 irq_o ", ctx}, 32'(irq_o), 32'(|(req_in & m_en & ~m_type)));
    rd(8'h00, v); check({"R5 raw ", ctx}, v, req_in);
    rd(8'h04, v); check({"R5 irqstat ", ctx}, v, req_in & m_en & ~m_type);
    rd(8'h08, v); check({"R5 fiqstat ", ctx}, v, req_in & m_en & m_type);
    rd(8'h18, v); check({"R8 vect ", ctx}, v, exp_vect());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd7719));
    for (int s = 0; s < 16; s++) begin m_ctl[s] = '0; m_adr[s] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 fiq_o", 32'(fiq_o), 0);
    check("R1 irq_o", 32'(irq_o), 0);
    rd(8'h0C, v); check("R1 enable", v, 0);
    rd(8'h14, v); check("R1 type", v, 0);
    rd(8'h1C, v); check("R1 default", v, 0);
    rd(8'h18, v); check("R1 vect", v, 0);
    rd(8'h4C, v); check("R1 slot3 ctl", v, 0);

    for (int s = 0; s < 16; s++) wr(8'h80 + 8'(4 * s), 32'hA000_0000 + 32'(s * 16));
    wr(8'h1C, 32'hDEAD_0000);
    for (int s = 0; s < 16; s++) begin
      rd(8'h80 + 8'(4 * s), v); check("R7 slot addr readback", v, m_adr[s]);
    end

    // R2 / R3 set and clear semantics
    wr(8'h0C, 32'h0000_00F0);
    wr(8'h0C, 32'h0000_0003);
    rd(8'h0C, v); check("R2 set keeps earlier bits", v, 32'h0000_00F3);
    wr(8'h10, 32'h0000_0011);
    rd(8'h0C, v); check("R3 clear only ones", v, 32'h0000_00E2);
    rd(8'h10, v); check("R3 clear reads zero", v, 0);

    // R6 slot control masking
    wr(8'h40, 32'hFFFF_FFE5);
    rd(8'h40, v); check("R6 ctl field bits", v, 32'h0000_0025);

    // R9 no slot for pending source, R8 default
    wr(8'h40, 32'h0);
    req_in = 32'h0000_0002;
    settle();
    full_check("unmapped");

    // R8 priority: slot 2 and 5 both hit, slot 1 idle source
    wr(8'h44, 32'h20 | 32'd9);
    wr(8'h48, 32'h20 | 32'd5);
    wr(8'h54, 32'h20 | 32'd1);
    wr(8'h0C, 32'h0000_0222);
    req_in = 32'h0000_0022;
    settle();
    full_check("rank");

    // R10 fast source under slot 0 is skipped
    wr(8'h40, 32'h20 | 32'd5);
    wr(8'h14, 32'h0000_0020);
    settle();
    full_check("fast under slot0");
    rd(8'h18, v); check("R10 vect skips fast", v, m_adr[5]);

    // R4 fast output alone
    req_in = 32'h0000_0020;
    settle();
    full_check("fast only");

    // random rounds
    for (int it = 0; it < 150; it++) begin
      for (int k = 0; k < 3; k++) begin
        int op = int'($urandom_range(0, 5));
        logic [31:0] d = $urandom;
        logic [3:0] s = 4'($urandom_range(0, 15));
        case (op)
          0: wr(8'h0C, d);
          1: wr(8'h10, d & $urandom);
          2: wr(8'h14, d & $urandom);
          3: wr(8'h40 + 8'({s, 2'b00}), d);
          4: wr(8'h80 + 8'({s, 2'b00}), d);
          default: wr(8'h1C, d);
        endcase
      end
      req_in = $urandom & $urandom;
      settle();
      full_check("random");
      begin
        logic [3:0] s = 4'($urandom_range(0, 15));
        rd(8'h40 + 8'({s, 2'b00}), v); check("R6 random ctl", v, 32'(m_ctl[s]));
        rd(8'h0C, v); check("R2 random enable", v, m_en);
      end
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule